// File: doc/BRIEF.md
# Configurable Command/Address Register with Parity Check

This block is the clocked command/address stage of a registered memory module. On every rising clock edge it captures its data input bus and drives the result onto registered outputs. A two-bit configuration input picks the topology. In the wide topology each of 25 inputs feeds one output. In the paired topology 14 inputs each feed two outputs. The paired topology also gives the device one of two roles, front or back. The role sets which slice of the input bus it uses and which side of the parity cascade it plays.

The block checks even parity over the data bits it handles. The parity bit arrives one clock after its data. An error shows as an active-low flag, and each detected error holds that flag low for at least two cycles. In the front role the device does not raise errors. It sends its partial parity to the back device, which adds that partial parity into its own check. Together the pair then checks all 28 data bits. While no chip select is active, the outputs keep their last value and no parity check is made.

The error flag is driven by a three-state machine. **ST_IDLE** drives the flag high. **ST_FLAG** and **ST_HOLD** drive it low. The transitions are:
- *detect*: ST_IDLE to ST_FLAG.
- *extend*: ST_FLAG to ST_HOLD, taken on every cycle.
- *retrigger*: ST_HOLD to ST_FLAG, taken on a new detection.
- *clear*: ST_HOLD to ST_IDLE, taken when there is no detection.

Reset returns the machine to ST_IDLE from any state.

Top module: `cmdaddr_regbuf`

## Requirements
- R1: When `cfg[0]`=0 (wide topology), one edge after a capture with a chip select active, `dout[24:0]` equals the captured `din[24:0]` and `dout[27:25]` is 0.
- R2: When `cfg`=2'b01 (paired topology, front role), one edge after a capture, `dout[13:0]` and `dout[27:14]` both equal the captured `din[13:0]`.
- R3: When `cfg`=2'b11 (paired topology, back role), one edge after a capture, `dout[13:0]` and `dout[27:14]` both equal the captured `din[24:11]`.
- R4: A chip select is active when its `cs_n` bit is 0. On an edge where both `cs_n` bits are 1, `dout` keeps its value.
- R5: In the wide topology, data captured at edge k is checked together with `par_in` sampled at edge k+1. If the total count of ones is odd, `err_n` is 0 after edge k+2.
- R6: An isolated detected error holds `err_n` at 0 for exactly two cycles, after which it returns to 1. A second error detected while the flag is low keeps it low.
- R7: Data captured while both chip selects are inactive is never checked, so a wrong parity bit for that data leaves `err_n` at 1.
- R8: In the front role, `ppo_out` after edge k+1 equals the XOR of `din[13:0]` captured at edge k and `par_in` sampled at edge k+1, and `err_n` stays 1. In the other topologies `ppo_out` is 0.
- R9: In the back role, the check at edge k+2 takes the XOR of the `din[24:11]` captured at edge k, `par_in` sampled at k+1, and `ppo_in` present at edge k+2. If the result is 1, `err_n` is 0.
- R10: Reset is synchronous and active low. After an edge with `rst_n`=0, `dout` is 0, `err_n` is 1 and `ppo_out` is 0, and any check still in the pipeline is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 2 | Topology and role select, held static outside reset |
| cs_n | input | 2 | Active-low chip selects |
| din | input | 25 | Command/address data inputs |
| par_in | input | 1 | Even-parity bit, one cycle after its data |
| ppo_in | input | 1 | Partial parity from the front device (back role only) |
| dout | output | 28 | Registered data outputs |
| err_n | output | 1 | Active-low parity error flag |
| ppo_out | output | 1 | Partial parity to the back device (front role only) |

## Verification
Two functions can act in the same cycle: the error flag being held low by the two-cycle extension, and a new detection arriving from the parity pipeline. The stimulus table places bad parity bits on consecutive captures. The bench checks that the retrigger keeps `err_n` low with no high gap, and that the flag clears two cycles after the last error. Reset is also asserted while a check is still in flight, to confirm the pending error never reaches `err_n`. The cascade is exercised with a front and a back device wired together, using both correct and wrong parity bits.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE   = 2'd0,
        MODE_PAIR_A = 2'd1,
        MODE_PAIR_B = 2'd2
    } topo_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FLAG = 2'd1,
        ST_HOLD = 2'd2
    } flag_st_e;

    function automatic topo_e decode_topo(input logic [1:0] cfg);
        if (!cfg[0])     return MODE_WIDE;
        else if (cfg[1]) return MODE_PAIR_B;
        else             return MODE_PAIR_A;
    endfunction

endpackage

// File: rtl/rbuf_lane_map.sv
module rbuf_lane_map
    import rbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int OUT_W    = 28
) (
    input  topo_e               topo,
    input  logic [WIDE_W-1:0]   din,
    output logic [OUT_W-1:0]    nxt_dout,
    output logic                lane_par
);
    localparam int B_LO = WIDE_W - NARROW_W;

    logic [NARROW_W-1:0] sel_bits;
    logic [OUT_W-1:0]    wide_v;
    logic [OUT_W-1:0]    pair_v;

    always_comb begin
        if (topo == MODE_PAIR_B) sel_bits = din[WIDE_W-1:B_LO];
        else                     sel_bits = din[NARROW_W-1:0];
    end

    for (genvar g = 0; g < OUT_W; g++) begin : g_lane
        if (g < WIDE_W) begin : g_wide
            assign wide_v[g] = din[g];
        end else begin : g_wide_pad
            assign wide_v[g] = 1'b0;
        end
        if (g < 2 * NARROW_W) begin : g_pair
            assign pair_v[g] = sel_bits[g % NARROW_W];
        end else begin : g_pair_pad
            assign pair_v[g] = 1'b0;
        end
    end

    always_comb begin
        if (topo == MODE_WIDE) begin
            nxt_dout = wide_v;
            lane_par = ^din;
        end else begin
            nxt_dout = pair_v;
            lane_par = ^sel_bits;
        end
    end
endmodule

// File: rtl/rbuf_out_reg.sv
module rbuf_out_reg #(
    parameter int OUT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OUT_W-1:0] nxt,
    output logic [OUT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= nxt;
    end
endmodule

// File: rtl/rbuf_parity_pipe.sv
module rbuf_parity_pipe
    import rbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  topo_e topo,
    input  logic  cs_act,
    input  logic  lane_par,
    input  logic  par_in,
    input  logic  ppo_in,
    output logic  err_det,
    output logic  ppo_out
);
    logic dpar_q;
    logic cs1_q;
    logic sum_q;
    logic cs2_q;
    logic bad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpar_q <= 1'b0;
            cs1_q  <= 1'b0;
            sum_q  <= 1'b0;
            cs2_q  <= 1'b0;
        end else begin
            dpar_q <= lane_par;
            cs1_q  <= cs_act;
            sum_q  <= dpar_q ^ par_in;
            cs2_q  <= cs1_q;
        end
    end

    always_comb begin
        unique case (topo)
            MODE_WIDE:   bad = sum_q;
            MODE_PAIR_B: bad = sum_q ^ ppo_in;
            default:     bad = 1'b0;
        endcase
        err_det = cs2_q & bad;
        ppo_out = (topo == MODE_PAIR_A) ? sum_q : 1'b0;
    end
endmodule

// File: rtl/rbuf_err_fsm.sv
module rbuf_err_fsm
    import rbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_det,
    output logic err_n
);
    flag_st_e state_q;
    flag_st_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = err_det ? ST_FLAG : ST_IDLE;
            ST_FLAG: state_d = ST_HOLD;
            ST_HOLD: state_d = err_det ? ST_FLAG : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FLAG, ST_HOLD: err_n = 1'b0;
            default:          err_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/cmdaddr_regbuf.sv
module cmdaddr_regbuf
    import rbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int CS_W     = 2,
    parameter int OUT_W    = (WIDE_W > 2 * NARROW_W) ? WIDE_W : 2 * NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg,
    input  logic [CS_W-1:0]   cs_n,
    input  logic [WIDE_W-1:0] din,
    input  logic              par_in,
    input  logic              ppo_in,
    output logic [OUT_W-1:0]  dout,
    output logic              err_n,
    output logic              ppo_out
);
    topo_e            topo;
    logic             cs_act;
    logic [OUT_W-1:0] nxt_dout;
    logic             lane_par;
    logic             err_det;

    always_comb begin
        topo   = decode_topo(cfg);
        cs_act = ~&cs_n;
    end

    rbuf_lane_map #(
        .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)
    ) u_map (
        .topo(topo), .din(din), .nxt_dout(nxt_dout), .lane_par(lane_par)
    );

    rbuf_out_reg #(.OUT_W(OUT_W)) u_oreg (
        .clk(clk), .rst_n(rst_n), .load(cs_act), .nxt(nxt_dout), .q(dout)
    );

    rbuf_parity_pipe u_par (
        .clk(clk), .rst_n(rst_n), .topo(topo), .cs_act(cs_act),
        .lane_par(lane_par), .par_in(par_in), .ppo_in(ppo_in),
        .err_det(err_det), .ppo_out(ppo_out)
    );

    rbuf_err_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .err_det(err_det), .err_n(err_n)
    );
endmodule

// File: rtl/cmdaddr_regbuf_chk.sv
module cmdaddr_regbuf_chk #(
    parameter int NARROW_W = 14,
    parameter int CS_W     = 2,
    parameter int OUT_W    = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg,
    input logic [CS_W-1:0]  cs_n,
    input logic [OUT_W-1:0] dout,
    input logic             err_n,
    input logic             ppo_out
);
    logic rst_low_q = 1'b0;

    always @(posedge clk) rst_low_q <= !rst_n;

    // R10: outputs are in their reset values after a reset edge
    always @(negedge clk) begin
        if (rst_low_q) begin
            a_reset_r10: assert (dout == '0 && err_n && !ppo_out)
                else $error("reset state wrong");
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |=> $stable(dout));

    p_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[0] |=> (dout[NARROW_W-1:0] == dout[2*NARROW_W-1:NARROW_W]));

    p_err_min_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

    p_front_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b01) |-> err_n);

    p_ppo_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != 2'b01) |-> !ppo_out);
endmodule

bind cmdaddr_regbuf cmdaddr_regbuf_chk #(
    .NARROW_W(NARROW_W), .CS_W(CS_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cs_n(cs_n),
    .dout(dout), .err_n(err_n), .ppo_out(ppo_out)
);

// File: tb/cmdaddr_regbuf_tb.sv
module cmdaddr_regbuf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg = 2'b00;
    logic [1:0]  cs_n = 2'b11;
    logic [24:0] din = '0;
    logic [13:0] din_a = '0;
    logic        par_in = 1'b0;
    logic        par_a = 1'b0;
    logic [27:0] dout;
    logic        err_n, ppo_out;
    logic [27:0] a_dout;
    logic        a_err_n, a_ppo;

    int checks = 0;
    int errors = 0;
    int mode = 0;

    // bench model state
    logic [27:0] m_dout;
    logic m_dpar, m_cs1, m_sum, m_cs2, m_ppo, ma_dpar, ma_sum;
    int   m_st;

    always #4 clk = ~clk;

    cmdaddr_regbuf u_pa (
        .clk(clk), .rst_n(rst_n), .cfg(2'b01), .cs_n(cs_n), .din({11'b0, din_a}),
        .par_in(par_a), .ppo_in(1'b0), .dout(a_dout), .err_n(a_err_n), .ppo_out(a_ppo)
    );

    cmdaddr_regbuf u_dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cs_n(cs_n), .din(din),
        .par_in(par_in), .ppo_in(a_ppo), .dout(dout), .err_n(err_n), .ppo_out(ppo_out)
    );

    // {cs_n[1:0], flip, din[24:0]}
    localparam logic [27:0] VEC [12] = '{
        {2'b00, 1'b0, 25'h1ABCDEF}, {2'b10, 1'b1, 25'h0000001},
        {2'b01, 1'b0, 25'h1FFFFFF}, {2'b11, 1'b1, 25'h0F0F0F0},
        {2'b00, 1'b1, 25'h0123456}, {2'b00, 1'b1, 25'h1800800},
        {2'b10, 1'b0, 25'h0000000}, {2'b11, 1'b0, 25'h1555555},
        {2'b11, 1'b0, 25'h0AAAAAA}, {2'b01, 1'b1, 25'h1FFF800},
        {2'b00, 1'b0, 25'h00007FF}, {2'b00, 1'b0, 25'h1234567}
    };

    function automatic logic [27:0] exp_dout(int md, logic [24:0] d);
        if (md == 0) return {3'b0, d};
        if (md == 1) return {d[13:0], d[13:0]};
        return {d[24:11], d[24:11]};
    endfunction

    function automatic logic hpar(int md, logic [24:0] d);
        if (md == 0) return ^d;
        if (md == 1) return ^d[13:0];
        return ^d[24:11];
    endfunction

    task automatic check(string req, logic [27:0] act, logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [24:0] d, logic [13:0] da, logic [1:0] csn,
                        logic p, logic pa, logic rn, string dtag);
        logic det;
        @(negedge clk);
        din = d; din_a = da; cs_n = csn; par_in = p; par_a = pa; rst_n = rn;
        @(posedge clk);
        if (!rn) begin
            m_dout = '0; m_dpar = 0; m_cs1 = 0; m_sum = 0; m_cs2 = 0;
            m_ppo = 0; ma_dpar = 0; ma_sum = 0; m_st = 0;
        end else begin
            det = m_cs2 & ((mode == 0) ? m_sum : (mode == 2) ? (m_sum ^ ma_sum) : 1'b0);
            case (m_st)
                0: m_st = det ? 1 : 0;
                1: m_st = 2;
                default: m_st = det ? 1 : 0;
            endcase
            m_ppo  = (mode == 1) ? (m_dpar ^ p) : 1'b0;
            m_sum  = m_dpar ^ p;
            m_cs2  = m_cs1;
            m_dpar = hpar(mode, d);
            m_cs1  = ~&csn;
            if (~&csn) m_dout = exp_dout(mode, d);
            ma_sum  = ma_dpar ^ pa;
            ma_dpar = ^da;
        end
        #2;
        check(dtag, dout, m_dout);
        check(mode == 0 ? "R5" : mode == 1 ? "R8" : "R9", {27'b0, err_n}, {27'b0, m_st == 0});
        check("R8", {27'b0, ppo_out}, {27'b0, m_ppo});
        check("R8 front err", {27'b0, a_err_n}, 28'd1);
    endtask

    task automatic restart(int md);
        mode = md;
        cfg = (md == 0) ? 2'b00 : (md == 1) ? 2'b01 : 2'b11;
        step('0, '0, 2'b11, 0, 0, 0, "R10");
        check("R10 dout", dout, '0);
        check("R10 err_n", {27'b0, err_n}, 28'd1);
        check("R10 ppo", {27'b0, ppo_out}, 28'd0);
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // table walk in each topology
        for (int md = 0; md < 3; md++) begin
            logic p;
            string tg;
            restart(md);
            p = 1'b0;
            for (int i = 0; i < 12; i++) begin
                tg = (VEC[i][27:26] == 2'b11) ? "R4" : (md == 0) ? "R1" : (md == 1) ? "R2" : "R3";
                step(VEC[i][24:0], '0, VEC[i][27:26], p, 0, 1, tg);
                p = hpar(md, VEC[i][24:0]) ^ VEC[i][25];
            end
            step('0, '0, 2'b11, p, 0, 1, "R4");
            for (int k = 0; k < 3; k++) step('0, '0, 2'b11, 0, 0, 1, "R4");
        end

        // R6: isolated error, flag low exactly two cycles
        restart(0);
        step(25'h1, '0, 2'b10, 0, 0, 1, "R1");
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        check("R6 k+1", {27'b0, err_n}, 28'd1);
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        check("R6 k+2", {27'b0, err_n}, 28'd0);
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        check("R6 k+3", {27'b0, err_n}, 28'd0);
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        check("R6 k+4", {27'b0, err_n}, 28'd1);

        // R7: bad parity on unselected data is ignored
        step(25'h1, '0, 2'b11, 0, 0, 1, "R4");
        for (int k = 0; k < 4; k++) begin
            step('0, '0, 2'b11, 0, 0, 1, "R4");
            check("R7", {27'b0, err_n}, 28'd1);
        end

        // R10: reset discards a pending error
        step(25'h1, '0, 2'b00, 0, 0, 1, "R1");
        step('0, '0, 2'b11, 0, 0, 0, "R10");
        for (int k = 0; k < 3; k++) begin
            step('0, '0, 2'b11, 0, 0, 1, "R10");
            check("R10 pending", {27'b0, err_n}, 28'd1);
            check("R10 dout", dout, '0);
        end

        // R9: cascade, correct then wrong parity
        restart(2);
        step(25'h0000800, 14'h0003, 2'b00, 0, 0, 1, "R3");
        step('0, '0, 2'b11, 0, 1, 1, "R4");
        check("R8 ppo_a", {27'b0, a_ppo}, 28'd1);
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        check("R9 good", {27'b0, err_n}, 28'd1);
        step(25'h0000800, 14'h0003, 2'b01, 0, 0, 1, "R3");
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        check("R9 bad", {27'b0, err_n}, 28'd0);
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        step('0, '0, 2'b11, 0, 0, 1, "R4");
        check("R9 clear", {27'b0, err_n}, 28'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule